// File: doc/BRIEF.md
# Flash Command Snoop Lane Tracker

This block rides alongside the transmit path of a quad-SPI flash master. It follows every byte the master shifts out while a chip select is active. It takes the first byte of each select window as a flash opcode, counts off the address and dummy bytes that follow, and tells the shifter two things about the next byte: how many data lanes to use (1, 2 or 4), and whether that byte is a dummy byte. For a dummy byte it also gives the number of clock cycles to emit.

It also decides whether each received byte goes into the receive FIFO. A per-session discard budget is loaded each time a chip select is asserted, and it suppresses the first received bytes in proportion to the lane width. A drain control drops all received data while it is set. The shifter and the FIFO are outside this block. The block sees one strobe per completed byte and reports the lane width and dummy status for the byte that comes after it.

Top module: `qspi_snoop_tracker`

## Requirements
- R1: The first byte sent after chip select asserts is decoded as an opcode. An opcode not in the recognised set (for example 0x9F or 0x00) sends the tracker straight to pass-through: no dummy bytes, and the lane width stays 1 for the rest of the session.
- R2: The address phase is 4 bytes for the 4-byte-address opcodes 0x13, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC, 0x12 and 0x34. For every other recognised opcode it is 4 bytes when ext_addr is 1 and 3 bytes when ext_addr is 0.
- R3: Dummy bytes follow the address phase, and their number depends on the opcode. There are none for 0x03, 0x13, 0x02, 0x12, 0xA2, 0x32 and 0x34. There is one for 0x0B, 0x3B, 0x3C, 0x6B and 0x6C. There are two for 0xBB, 0xBC and 0x0C, and five for 0xEB and 0xEC.
- R4: For the output-only opcodes 0x3B, 0x3C and 0xA2 (target width 2) and 0x6B, 0x6C, 0x32 and 0x34 (target width 4), the opcode, address and dummy bytes use width 1. The first byte after the dummy bytes uses the target width.
- R5: For the I/O opcodes 0xBB and 0xBC (width 2) and 0xEB and 0xEC (width 4), every byte after the opcode, including address and dummy bytes, uses the new width.
- R6: While the next byte is a dummy byte, dummy_cycles equals 8 divided by the current lane width. Otherwise it is 0. lane_width carries the binary value 1, 2 or 4.
- R7: While cs_idle is 1, the tracker returns to opcode decode, lane_width returns to 1 at the next clock edge, and any pending width change is cancelled.
- R8: On the first cycle after cs_idle falls, the discard counter loads discard_cfg. While the counter is non-zero, each received byte is dropped (rx_accept is 0) and the counter drops by 8 divided by the lane width of that byte, stopping at zero rather than wrapping.
- R9: While drain_en is 1, rx_accept is 0 for every byte, and the discard counter does not change.
- R10: After reset, lane_width is 1, dummy_cycles is 0 and rx_accept is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_idle | input | 1 | 1 when every chip select is deasserted |
| byte_sent | input | 1 | One-cycle strobe: a byte has completed on the bus |
| byte_val | input | 8 | Transmitted value of the completed byte |
| ext_addr | input | 1 | Selects 4-byte addresses for opcodes without a fixed length |
| discard_cfg | input | 7 | Discard budget loaded when chip select asserts |
| drain_en | input | 1 | Drop all received bytes while set |
| lane_width | output | 3 | Lane width for the next byte: 1, 2 or 4 |
| dummy_cycles | output | 4 | Clock cycles to emit if the next byte is a dummy, else 0 |
| rx_accept | output | 1 | The received byte of the current strobe goes to the FIFO |

## Verification
The assertions rely on the shifter raising byte_sent only while cs_idle is low, and never in the same cycle that cs_idle falls, so the discard load never competes with a decrement. The stimulus always holds the select idle for a few cycles, drops it, waits one full cycle, and only then starts strobing bytes, one per cycle. The sweep runs every recognised opcode and two unrecognised ones against both ext_addr settings, several discard budgets and both drain settings. Separate sessions are cut short mid-command, so a width change left pending would show up in the session that follows.

// File: rtl/qsnp_pkg.sv
// Package: shared sizes, opcode values, state and decode types for the
// flash command snoop lane tracker. Assumes lane widths of 1, 2 or 4 only.
package qsnp_pkg;

    localparam int LANE_W  = 3;   // lane width carried as binary 1/2/4
    localparam int CYC_W   = 4;   // dummy cycle count, up to 8
    localparam int PHASE_W = 3;   // address / dummy byte counters, up to 5

    localparam logic [7:0] OPC_RD      = 8'h03;
    localparam logic [7:0] OPC_RD4     = 8'h13;
    localparam logic [7:0] OPC_FRD     = 8'h0B;
    localparam logic [7:0] OPC_FRD4    = 8'h0C;
    localparam logic [7:0] OPC_DOUT    = 8'h3B;
    localparam logic [7:0] OPC_DOUT4   = 8'h3C;
    localparam logic [7:0] OPC_QOUT    = 8'h6B;
    localparam logic [7:0] OPC_QOUT4   = 8'h6C;
    localparam logic [7:0] OPC_DIO     = 8'hBB;
    localparam logic [7:0] OPC_DIO4    = 8'hBC;
    localparam logic [7:0] OPC_QIO     = 8'hEB;
    localparam logic [7:0] OPC_QIO4    = 8'hEC;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_PROG4   = 8'h12;
    localparam logic [7:0] OPC_DPROG   = 8'hA2;
    localparam logic [7:0] OPC_QPROG   = 8'h32;
    localparam logic [7:0] OPC_QPROG4  = 8'h34;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_ADDR   = 2'd1,
        ST_DUMMY  = 2'd2,
        ST_PASS   = 2'd3
    } snoop_st_e;

    typedef enum logic [1:0] {
        LSW_KEEP  = 2'd0,   // width unchanged
        LSW_NOW   = 2'd1,   // switch right after the opcode
        LSW_AFTER = 2'd2    // switch after address and dummy bytes
    } lane_sw_e;

    typedef struct packed {
        logic               known;
        logic [PHASE_W-1:0] addr_bytes;
        logic [PHASE_W-1:0] dummy_bytes;
        lane_sw_e           sw;
        logic [LANE_W-1:0]  target_w;
    } opc_info_t;

    // Clock cycles one byte takes at the given lane width
    function automatic logic [CYC_W-1:0] cycles_per_byte(input logic [LANE_W-1:0] w);
        case (w)
            3'd2:    cycles_per_byte = 4'd4;
            3'd4:    cycles_per_byte = 4'd2;
            default: cycles_per_byte = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/qsnp_opcode_decode.sv
// Opcode decoder: maps one opcode byte to its address length, dummy byte
// count and lane-switch behaviour. Purely combinational; the caller uses
// the result only on the first byte of a select window.
module qsnp_opcode_decode
    import qsnp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] opcode,
    input  logic              ext_addr,
    output opc_info_t         info
);

    localparam logic [PHASE_W-1:0] ADDR_FIXED4 = PHASE_W'(4);

    logic [PHASE_W-1:0] addr_var;

    // Address length for opcodes whose length follows ext_addr
    always_comb addr_var = ext_addr ? PHASE_W'(4) : PHASE_W'(3);

    // Table lookup of the opcode properties
    always_comb begin
        info             = '0;
        info.known       = 1'b1;
        info.sw          = LSW_KEEP;
        info.target_w    = LANE_W'(1);
        info.addr_bytes  = addr_var;
        info.dummy_bytes = '0;
        case (opcode[7:0])
            OPC_RD:     ;
            OPC_RD4:    info.addr_bytes = ADDR_FIXED4;
            OPC_PROG:   ;
            OPC_PROG4:  info.addr_bytes = ADDR_FIXED4;
            OPC_FRD:    info.dummy_bytes = PHASE_W'(1);
            OPC_FRD4: begin
                info.addr_bytes  = ADDR_FIXED4;
                info.dummy_bytes = PHASE_W'(2);
            end
            OPC_DOUT, OPC_DOUT4: begin
                if (opcode[7:0] == OPC_DOUT4) info.addr_bytes = ADDR_FIXED4;
                info.dummy_bytes = PHASE_W'(1);
                info.sw          = LSW_AFTER;
                info.target_w    = LANE_W'(2);
            end
            OPC_QOUT, OPC_QOUT4: begin
                if (opcode[7:0] == OPC_QOUT4) info.addr_bytes = ADDR_FIXED4;
                info.dummy_bytes = PHASE_W'(1);
                info.sw          = LSW_AFTER;
                info.target_w    = LANE_W'(4);
            end
            OPC_DPROG: begin
                info.sw       = LSW_AFTER;
                info.target_w = LANE_W'(2);
            end
            OPC_QPROG, OPC_QPROG4: begin
                if (opcode[7:0] == OPC_QPROG4) info.addr_bytes = ADDR_FIXED4;
                info.sw       = LSW_AFTER;
                info.target_w = LANE_W'(4);
            end
            OPC_DIO, OPC_DIO4: begin
                if (opcode[7:0] == OPC_DIO4) info.addr_bytes = ADDR_FIXED4;
                info.dummy_bytes = PHASE_W'(2);
                info.sw          = LSW_NOW;
                info.target_w    = LANE_W'(2);
            end
            OPC_QIO, OPC_QIO4: begin
                if (opcode[7:0] == OPC_QIO4) info.addr_bytes = ADDR_FIXED4;
                info.dummy_bytes = PHASE_W'(5);
                info.sw          = LSW_NOW;
                info.target_w    = LANE_W'(4);
            end
            default: begin
                info.known      = 1'b0;
                info.addr_bytes = '0;
            end
        endcase
    end

endmodule

// File: rtl/qsnp_lane_ctrl.sv
// Lane controller: holds the current lane width and an optional pending
// switch that takes effect after a byte countdown. Assumes adv is raised
// only while a chip select is active.
module qsnp_lane_ctrl
    import qsnp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              adv,
    input  logic              opc_fire,
    input  opc_info_t         info,
    output logic [LANE_W-1:0] lane_w
);

    logic [CNT_W-1:0]  pend_cnt;
    logic [LANE_W-1:0] pend_w;
    logic [CNT_W-1:0]  pend_load;

    // Bytes that must pass before a deferred switch applies
    always_comb pend_load = CNT_W'(info.addr_bytes) + CNT_W'(info.dummy_bytes);

    // Width register with immediate and deferred updates
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            lane_w   <= LANE_W'(1);
            pend_cnt <= '0;
            pend_w   <= LANE_W'(1);
        end else if (adv) begin
            if (opc_fire) begin
                if (info.sw == LSW_NOW) begin
                    lane_w <= info.target_w;
                end else if (info.sw == LSW_AFTER) begin
                    pend_cnt <= pend_load;
                    pend_w   <= info.target_w;
                end
            end else if (pend_cnt != '0) begin
                pend_cnt <= pend_cnt - CNT_W'(1);
                if (pend_cnt == CNT_W'(1)) lane_w <= pend_w;
            end
        end
    end

    // R4
    pending_from_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0) |-> (lane_w == LANE_W'(1)));

    // R6
    width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_w) == 1) && (lane_w <= LANE_W'(4)));

endmodule

// File: rtl/qsnp_rx_gate.sv
// Receive gate: loads a discard budget on each chip-select assertion and
// decides per received byte whether it reaches the FIFO. Assumes no byte
// strobe in the cycle where the select falls.
module qsnp_rx_gate
    import qsnp_pkg::*;
#(
    parameter int DISC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              byte_sent,
    input  logic              drain_en,
    input  logic [DISC_W-1:0] disc_cfg,
    input  logic [LANE_W-1:0] lane_w,
    output logic              rx_accept
);

    logic              cs_idle_q;
    logic [DISC_W-1:0] disc_cnt;
    logic [DISC_W-1:0] step;
    logic              cs_fall;
    logic              consume;

    // Per-byte decrement and event decode
    always_comb begin
        step    = DISC_W'(cycles_per_byte(lane_w));
        cs_fall = cs_idle_q && !cs_idle;
        consume = byte_sent && !cs_idle && !drain_en && (disc_cnt != '0);
    end

    // Accept only when selected, not draining and the budget is spent
    always_comb rx_accept = byte_sent && !cs_idle && !drain_en && (disc_cnt == '0);

    // Select edge tracker and saturating discard counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_idle_q <= 1'b1;
            disc_cnt  <= '0;
        end else begin
            cs_idle_q <= cs_idle;
            if (cs_fall) begin
                disc_cnt <= disc_cfg;
            end else if (consume) begin
                disc_cnt <= (disc_cnt > step) ? (disc_cnt - step) : '0;
            end
        end
    end

    // R8
    discard_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_sent && !cs_idle && !drain_en && !cs_fall && disc_cnt != '0)
        |=> (disc_cnt < $past(disc_cnt)));

    // R9
    drain_holds_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_sent && drain_en && !cs_fall) |=> $stable(disc_cnt));

endmodule

// File: rtl/qspi_snoop_tracker.sv
// Top: follows the bytes of one select window through opcode, address,
// dummy and pass-through phases, and reports lane width, dummy cycles and
// receive acceptance. Assumes byte_sent only while cs_idle is low.
module qspi_snoop_tracker
    import qsnp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISC_W = 7,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              byte_sent,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              ext_addr,
    input  logic [DISC_W-1:0] discard_cfg,
    input  logic              drain_en,
    output logic [LANE_W-1:0] lane_width,
    output logic [CYC_W-1:0]  dummy_cycles,
    output logic              rx_accept
);

    snoop_st_e          state;
    logic [PHASE_W-1:0] phase_cnt;
    logic [PHASE_W-1:0] dummy_q;
    opc_info_t          info;
    logic               adv;
    logic               opc_fire;

    qsnp_opcode_decode #(.BYTE_W(BYTE_W)) u_decode (
        .opcode   (byte_val),
        .ext_addr (ext_addr),
        .info     (info)
    );

    // Byte advance qualifiers
    always_comb begin
        adv      = byte_sent && !cs_idle;
        opc_fire = adv && (state == ST_OPCODE) && info.known;
    end

    // Phase sequencer over the bytes of one command
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            state     <= ST_OPCODE;
            phase_cnt <= '0;
            dummy_q   <= '0;
        end else if (adv) begin
            case (state)
                ST_OPCODE: begin
                    if (info.known) begin
                        state     <= ST_ADDR;
                        phase_cnt <= info.addr_bytes;
                        dummy_q   <= info.dummy_bytes;
                    end else begin
                        state <= ST_PASS;
                    end
                end
                ST_ADDR: begin
                    if (phase_cnt == PHASE_W'(1)) begin
                        state     <= (dummy_q == '0) ? ST_PASS : ST_DUMMY;
                        phase_cnt <= dummy_q;
                    end else begin
                        phase_cnt <= phase_cnt - PHASE_W'(1);
                    end
                end
                ST_DUMMY: begin
                    if (phase_cnt == PHASE_W'(1)) state <= ST_PASS;
                    phase_cnt <= phase_cnt - PHASE_W'(1);
                end
                default: state <= ST_PASS;
            endcase
        end
    end

    qsnp_lane_ctrl #(.CNT_W(CNT_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_idle  (cs_idle),
        .adv      (adv),
        .opc_fire (opc_fire),
        .info     (info),
        .lane_w   (lane_width)
    );

    // Dummy cycle report for the upcoming byte
    always_comb dummy_cycles = (state == ST_DUMMY) ? cycles_per_byte(lane_width) : '0;

    qsnp_rx_gate #(.DISC_W(DISC_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_idle   (cs_idle),
        .byte_sent (byte_sent),
        .drain_en  (drain_en),
        .disc_cfg  (discard_cfg),
        .lane_w    (lane_width),
        .rx_accept (rx_accept)
    );

    // R7
    idle_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (lane_width == LANE_W'(1)) && (dummy_cycles == '0));

    // R6
    dummy_fills_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_cycles != '0) |-> (int'(dummy_cycles) * int'(lane_width) == 8));

    // R1
    unknown_stays_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state == ST_OPCODE && !info.known) |=> (lane_width == LANE_W'(1)));

endmodule

// File: tb/qspi_snoop_tracker_tb.sv
`timescale 1ns/1ps
module qspi_snoop_tracker_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_idle;
    logic       byte_sent;
    logic [7:0] byte_val;
    logic       ext_addr;
    logic [6:0] discard_cfg;
    logic       drain_en;
    logic [2:0] lane_width;
    logic [3:0] dummy_cycles;
    logic       rx_accept;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    qspi_snoop_tracker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_idle      (cs_idle),
        .byte_sent    (byte_sent),
        .byte_val     (byte_val),
        .ext_addr     (ext_addr),
        .discard_cfg  (discard_cfg),
        .drain_en     (drain_en),
        .lane_width   (lane_width),
        .dummy_cycles (dummy_cycles),
        .rx_accept    (rx_accept)
    );

    localparam logic [7:0] OPS [19] = '{
        8'h03, 8'h13, 8'h0B, 8'h0C, 8'h3B, 8'h3C, 8'h6B, 8'h6C, 8'hBB,
        8'hBC, 8'hEB, 8'hEC, 8'h02, 8'h12, 8'hA2, 8'h32, 8'h34, 8'h9F, 8'h00};
    localparam int DISC [4] = '{0, 5, 16, 127};

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Spec table: address bytes, dummy bytes, switch mode (0 keep, 1 now, 2 after)
    task automatic spec(input logic [7:0] op, input bit a4, output bit known,
                        output int alen, output int dum, output int mode, output int tw);
        int base;
        base  = a4 ? 4 : 3;
        known = 1'b1; alen = base; dum = 0; mode = 0; tw = 1;
        case (op)
            8'h03, 8'h02: ;
            8'h13, 8'h12: alen = 4;
            8'h0B: dum = 1;
            8'h0C: begin alen = 4; dum = 2; end
            8'h3B: begin dum = 1; mode = 2; tw = 2; end
            8'h3C: begin alen = 4; dum = 1; mode = 2; tw = 2; end
            8'h6B: begin dum = 1; mode = 2; tw = 4; end
            8'h6C: begin alen = 4; dum = 1; mode = 2; tw = 4; end
            8'hA2: begin mode = 2; tw = 2; end
            8'h32: begin mode = 2; tw = 4; end
            8'h34: begin alen = 4; mode = 2; tw = 4; end
            8'hBB: begin dum = 2; mode = 1; tw = 2; end
            8'hBC: begin alen = 4; dum = 2; mode = 1; tw = 2; end
            8'hEB: begin dum = 5; mode = 1; tw = 4; end
            8'hEC: begin alen = 4; dum = 5; mode = 1; tw = 4; end
            default: begin known = 1'b0; alen = 0; end
        endcase
    endtask

    // One select window: opcode plus 12 further bytes, all checked
    task automatic run_txn(input logic [7:0] op, input bit a4, input int disc, input bit drn);
        bit known; int alen, dum, mode, tw, dc, ew, ed, step;
        byte_sent = 1'b0; cs_idle = 1'b1;
        ext_addr = a4; discard_cfg = 7'(disc); drain_en = drn;
        spec(op, a4, known, alen, dum, mode, tw);
        @(negedge clk); @(negedge clk);
        chk(lane_width, 1, "R7 width while idle");
        cs_idle = 1'b0;
        @(negedge clk);
        dc = disc;
        for (int k = 0; k <= 12; k++) begin
            ew = 1;
            if (known && mode == 1 && k >= 1) ew = tw;
            if (known && mode == 2 && k > alen + dum) ew = tw;
            ed = (known && k > alen && k <= alen + dum) ? 8 / ew : 0;
            if (!known)         chk(lane_width, ew, "R1 width");
            else if (mode == 1) chk(lane_width, ew, "R5 width");
            else if (mode == 2) chk(lane_width, ew, "R4 width");
            else                chk(lane_width, ew, "R2 width");
            if (known && k == alen)     chk(dummy_cycles, ed, "R2 last address byte");
            else if (ed != 0)           chk(dummy_cycles, ed, "R6 dummy cycles");
            else                        chk(dummy_cycles, ed, "R3 no dummy");
            byte_val  = (k == 0) ? op : 8'(8'hA5 ^ k);
            byte_sent = 1'b1;
            #1;
            if (drn) chk(rx_accept, 0, "R9 drain drop");
            else     chk(rx_accept, (dc == 0) ? 1 : 0, "R8 discard gate");
            step = 8 / ew;
            if (!drn && dc != 0) dc = (dc > step) ? dc - step : 0;
            @(negedge clk);
            byte_sent = 1'b0;
        end
        cs_idle = 1'b1;
    endtask

    // Window cut short after the opcode and one byte
    task automatic cut_short(input logic [7:0] op);
        cs_idle = 1'b1; byte_sent = 1'b0; drain_en = 1'b0; discard_cfg = '0;
        @(negedge clk);
        cs_idle = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            byte_val = (k == 0) ? op : 8'h00;
            byte_sent = 1'b1;
            @(negedge clk);
            byte_sent = 1'b0;
        end
        cs_idle = 1'b1;
        @(negedge clk);
        chk(lane_width, 1, "R7 width after cut");
        chk(dummy_cycles, 0, "R7 dummy after cut");
        run_txn(8'h03, 1'b0, 0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; cs_idle = 1'b1; byte_sent = 1'b0; byte_val = '0;
        ext_addr = 1'b0; discard_cfg = '0; drain_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lane_width, 1, "R10 reset width");
        chk(dummy_cycles, 0, "R10 reset dummy");
        chk(rx_accept, 0, "R10 reset accept");
        foreach (OPS[i])
            for (int a = 0; a < 2; a++)
                for (int d = 0; d < 4; d++)
                    for (int r = 0; r < 2; r++)
                        run_txn(OPS[i], a[0], DISC[d], r[0]);
        cut_short(8'h6B);
        cut_short(8'h3C);
        cut_short(8'hEB);
        cut_short(8'hBB);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule